// File: doc/BRIEF.md
# SMM Memory Access Decoder

This block sits in the memory request path of a host bridge. It looks at each request and decides where it goes: to DRAM, forwarded to the I/O hub, or terminated at once with no memory access. It guards two protected regions used by system management mode. The high segment is a fixed 128 KB window near the top of the address space. Hits in that window are redirected into the legacy 000A0000h–000BFFFFh range, and the offset inside the window is kept. The top segment lies directly below top of memory. Hits there go to DRAM at the same address.

A request is allowed into a protected region when the processor is in management mode. It is also allowed when the cycle is a cache write-back, so that evicted lines still land in protected storage. Any other processor access to an enabled region is terminated. Requests from the hub-side agent that hit an enabled region are sent back to the hub and never reach protected DRAM. The block also reports how much memory the system may use, which shrinks by the top segment size while that segment is enabled.

Each request is decoded in one cycle, and the response is registered with one cycle of latency.

Top module: `smm_route_decoder`

## Requirements
- R1: A request presented with `reqValid` high produces `rspValid` high exactly one clock later, and `rspValid` is low during and right after reset. Route codes: 2'b00 = DRAM, 2'b01 = forward to hub, 2'b10 = terminate.
- R2: With the high segment enabled, a management-mode processor access inside the high window returns route 2'b00 with address {legacy base upper bits, original low 17 bits}, i.e. within 000A0000h–000BFFFFh.
- R3: While the high segment is enabled, no response with route 2'b00 ever carries an address inside the high window.
- R4: With the top segment enabled, a management-mode processor access in [top − size, top) returns route 2'b00 with the address unchanged.
- R5: A processor access outside management mode, not a write-back, to an enabled segment returns route 2'b10 with address 0.
- R6: A non-management write-back to an enabled segment returns route 2'b00, translated for the high segment and unchanged for the top segment.
- R7: A hub-side request hitting an enabled segment returns route 2'b01 with its address unchanged, whatever the mode and write-back flags are.
- R8: `usableMem` equals top of memory minus the top segment size while the top segment is enabled, and equals top of memory otherwise.
- R9: When a segment's enable is clear, its addresses are decoded as ordinary memory, with no check of mode or source.
- R10: An address in neither enabled segment returns route 2'b00 unchanged when it is below top of memory, and route 2'b01 unchanged when it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Request address |
| reqFromHub | input | 1 | Request comes from the hub-side agent |
| reqSmm | input | 1 | Processor is in management mode |
| reqWb | input | 1 | Cycle is a cache write-back |
| cfgHsegEn | input | 1 | High segment enable |
| cfgTsegEn | input | 1 | Top segment enable |
| cfgTopOfMem | input | ADDR_W | Top of physical memory (byte address) |
| cfgTsegSize | input | ADDR_W | Top segment size in bytes |
| rspValid | output | 1 | Response valid |
| rspRoute | output | 2 | Routing decision |
| rspAddr | output | ADDR_W | Routed (possibly translated) address |
| usableMem | output | ADDR_W | Memory available to the system |

## Verification
The hardest case to create is a conflict between flags: a request that is both a write-back and from the hub, or one sitting exactly on a segment edge. Ordinary traffic rarely produces either of these. The driver therefore sets source, mode and write-back flags one by one against addresses at the first and last byte of each window. It also uses addresses one byte below the top segment, and it toggles each enable between requests. This shows that a cleared enable makes the region ordinary memory again on the very next cycle.

// File: rtl/smm_route_pkg.sv
package smm_route_pkg;
  typedef enum logic [1:0] {
    RT_DRAM = 2'b00,
    RT_HUB  = 2'b01,
    RT_KILL = 2'b10
  } route_e;

  typedef struct packed {
    logic useDram;
    logic translate;
    logic toHub;
    logic kill;
  } route_strobe_t;
endpackage

// File: rtl/smm_route_ctrl.sv
module smm_route_ctrl
  import smm_route_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          hsegHit,
  input  logic          tsegHit,
  input  logic          belowTom,
  input  logic          fromHub,
  input  logic          smmMode,
  input  logic          wbCycle,
  output route_strobe_t stb
);
  logic segHit;
  assign segHit = hsegHit | tsegHit;

  always_comb begin
    stb = '0;
    if (segHit) begin
      if (fromHub) begin
        stb.toHub = 1'b1;
      end else if (smmMode || wbCycle) begin
        stb.useDram   = 1'b1;
        stb.translate = hsegHit;
      end else begin
        stb.kill = 1'b1;
      end
    end else if (belowTom) begin
      stb.useDram = 1'b1;
    end else begin
      stb.toHub = 1'b1;
    end
  end

  // R7: hub-side traffic into protected space never reaches DRAM
  p_hub_blocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (segHit && fromHub) |-> !stb.useDram);

  // R1: exactly one routing strobe per decode
  p_single_route_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.useDram, stb.toHub, stb.kill}) == 1);
endmodule

// File: rtl/smm_route_dp.sv
module smm_route_dp
  import smm_route_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter int              HSEG_BYTES  = 131072,
  parameter logic [ADDR_W-1:0] HSEG_BASE   = 32'hFEDA0000,
  parameter logic [ADDR_W-1:0] LEGACY_BASE = 32'h000A0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              cfgHsegEn,
  input  logic              cfgTsegEn,
  input  logic [ADDR_W-1:0] cfgTopOfMem,
  input  logic [ADDR_W-1:0] cfgTsegSize,
  input  route_strobe_t     stb,
  output logic              hsegHit,
  output logic              tsegHit,
  output logic              belowTom,
  output logic              rspValid,
  output logic [1:0]        rspRoute,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [ADDR_W-1:0] usableMem
);
  localparam int WIN_W = $clog2(HSEG_BYTES);

  logic [ADDR_W-1:0] tsegBase;
  logic [ADDR_W-1:0] nextAddr;
  route_e            nextRoute;

  assign tsegBase  = cfgTopOfMem - cfgTsegSize;
  assign belowTom  = reqAddr < cfgTopOfMem;
  assign hsegHit   = cfgHsegEn && (reqAddr[ADDR_W-1:WIN_W] == HSEG_BASE[ADDR_W-1:WIN_W]);
  assign tsegHit   = cfgTsegEn && (reqAddr >= tsegBase) && belowTom;
  assign usableMem = cfgTsegEn ? tsegBase : cfgTopOfMem;

  always_comb begin
    if (stb.kill)
      nextAddr = '0;
    else if (stb.translate)
      nextAddr = {LEGACY_BASE[ADDR_W-1:WIN_W], reqAddr[WIN_W-1:0]};
    else
      nextAddr = reqAddr;

    if (stb.kill)       nextRoute = RT_KILL;
    else if (stb.toHub) nextRoute = RT_HUB;
    else                nextRoute = RT_DRAM;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRoute <= RT_DRAM;
      rspAddr  <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspRoute <= nextRoute;
        rspAddr  <= nextAddr;
      end
    end
  end

  // R1: one-cycle latency of the valid flag
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R3: no raw DRAM access inside the enabled high window
  p_no_raw_hseg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cfgHsegEn) |=>
      (rspRoute != RT_DRAM || rspAddr[ADDR_W-1:WIN_W] != HSEG_BASE[ADDR_W-1:WIN_W]));

  // R4: top segment DRAM accesses keep their address
  p_tseg_identity_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && tsegHit && !hsegHit && stb.useDram) |=> (rspAddr == $past(reqAddr)));
endmodule

// File: rtl/smm_route_decoder.sv
module smm_route_decoder
  import smm_route_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter int              HSEG_BYTES  = 131072,
  parameter logic [ADDR_W-1:0] HSEG_BASE   = 32'hFEDA0000,
  parameter logic [ADDR_W-1:0] LEGACY_BASE = 32'h000A0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqFromHub,
  input  logic              reqSmm,
  input  logic              reqWb,
  input  logic              cfgHsegEn,
  input  logic              cfgTsegEn,
  input  logic [ADDR_W-1:0] cfgTopOfMem,
  input  logic [ADDR_W-1:0] cfgTsegSize,
  output logic              rspValid,
  output logic [1:0]        rspRoute,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [ADDR_W-1:0] usableMem
);
  route_strobe_t stb;
  logic hsegHit, tsegHit, belowTom;

  smm_route_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .hsegHit(hsegHit), .tsegHit(tsegHit), .belowTom(belowTom),
    .fromHub(reqFromHub), .smmMode(reqSmm), .wbCycle(reqWb),
    .stb(stb)
  );

  smm_route_dp #(
    .ADDR_W(ADDR_W), .HSEG_BYTES(HSEG_BYTES),
    .HSEG_BASE(HSEG_BASE), .LEGACY_BASE(LEGACY_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqAddr(reqAddr),
    .cfgHsegEn(cfgHsegEn), .cfgTsegEn(cfgTsegEn),
    .cfgTopOfMem(cfgTopOfMem), .cfgTsegSize(cfgTsegSize),
    .stb(stb),
    .hsegHit(hsegHit), .tsegHit(tsegHit), .belowTom(belowTom),
    .rspValid(rspValid), .rspRoute(rspRoute), .rspAddr(rspAddr),
    .usableMem(usableMem)
  );
endmodule

// File: tb/smm_route_decoder_bench.sv
module smm_route_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HBASE = 32'hFEDA0000;
  localparam logic [31:0] TOM   = 32'h10000000;
  localparam logic [31:0] TSIZE = 32'h00100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic reqFromHub = 1'b0, reqSmm = 1'b0, reqWb = 1'b0;
  logic cfgHsegEn = 1'b0, cfgTsegEn = 1'b0;
  logic [31:0] cfgTopOfMem = TOM;
  logic [31:0] cfgTsegSize = TSIZE;
  logic rspValid;
  logic [1:0] rspRoute;
  logic [31:0] rspAddr, usableMem;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0]  route;
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_route_decoder u_smm_route_decoder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqFromHub(reqFromHub), .reqSmm(reqSmm), .reqWb(reqWb),
    .cfgHsegEn(cfgHsegEn), .cfgTsegEn(cfgTsegEn),
    .cfgTopOfMem(cfgTopOfMem), .cfgTsegSize(cfgTsegSize),
    .rspValid(rspValid), .rspRoute(rspRoute), .rspAddr(rspAddr),
    .usableMem(usableMem)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input bit hub, input bit smm, input bit wb,
                      input bit hEn, input bit tEn, input string tag);
    exp_t e;
    bit hs, ts;
    hs = hEn && a >= HBASE && a < HBASE + 32'h20000;
    ts = tEn && a >= TOM - TSIZE && a < TOM;
    e.tag = tag;
    if (hs || ts) begin
      if (hub) begin e.route = 2'b01; e.addr = a; end
      else if (smm || wb) begin
        e.route = 2'b00;
        e.addr  = hs ? (32'h000A0000 + (a - HBASE)) : a;
      end else begin e.route = 2'b10; e.addr = 32'h0; end
    end else if (a < TOM) begin e.route = 2'b00; e.addr = a; end
    else begin e.route = 2'b01; e.addr = a; end
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqFromHub = hub; reqSmm = smm; reqWb = wb;
    cfgHsegEn = hEn; cfgTsegEn = tEn;
    expQ.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected response", {30'b0, rspRoute}, 32'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(rspRoute == e.route, {e.tag, " route"}, {30'b0, rspRoute}, {30'b0, e.route});
        check(rspAddr == e.addr, {e.tag, " addr"}, rspAddr, e.addr);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rspValid == 1'b0, "R1 reset valid", {31'b0, rspValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 1'b0, "R1 idle after reset", {31'b0, rspValid}, 32'h0);

    cfgTsegEn = 1'b1; #1;
    check(usableMem == TOM - TSIZE, "R8 usable tseg on", usableMem, TOM - TSIZE);
    cfgTsegEn = 1'b0; #1;
    check(usableMem == TOM, "R8 usable tseg off", usableMem, TOM);

    send(32'hFEDA1234, 0, 1, 0, 1, 1, "R2 hseg smm");
    send(32'hFEDBFFFF, 0, 1, 0, 1, 1, "R2 hseg smm top byte");
    send(32'hFEDA0000, 0, 0, 0, 1, 1, "R5 hseg non-smm kill");
    send(32'h0FF80000, 0, 0, 0, 1, 1, "R5 tseg non-smm kill");
    send(32'hFEDA4000, 0, 0, 1, 1, 1, "R6 hseg writeback");
    send(32'h0FFFFFC0, 0, 0, 1, 1, 1, "R6 tseg writeback");
    send(32'h0FF00000, 0, 1, 0, 1, 1, "R4 tseg smm low edge");
    send(32'h0FFFFFFF, 0, 1, 0, 1, 1, "R4 tseg smm high edge");
    send(32'h0FEFFFFF, 0, 0, 0, 1, 1, "R10 below tseg");
    send(32'hFEDA8000, 1, 1, 1, 1, 1, "R7 hub hseg");
    send(32'h0FF10000, 1, 0, 1, 1, 1, "R7 hub tseg");
    send(32'hFEDA1234, 0, 0, 0, 0, 1, "R9 hseg disabled");
    send(32'h0FF80000, 0, 0, 0, 1, 0, "R9 tseg disabled");
    send(32'h00012345, 0, 0, 0, 1, 1, "R10 low dram");
    send(32'h20000000, 0, 1, 0, 1, 1, "R10 above tom");
    send(32'hFEDC0000, 0, 1, 0, 1, 1, "R3 past hseg window");
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R1 all responses seen", expQ.size(), 32'h0);
    check(rspValid == 1'b0, "R1 idle valid", {31'b0, rspValid}, 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule